// File: doc/BRIEF.md
# Indexed General-Purpose Strobe Port

This block is a byte-wide I/O slave for a host bus with separate read and write commands. Each socket has an output strobe that can control an external latch or buffer. The host reaches the strobe logic through two levels of indirection:

- An index port selects a main index.
- For each socket, one main index opens a pointer register and the next opens a data window.
- The pointer value decides what the data window reaches: the socket's control byte or its external data port.

Host accesses to the external data port can pulse the socket strobe. An external buffer can then place status on the bus during a read, or an external latch can capture the written byte during a write. Each socket sets its own strobe qualification by direction, its polarity and its output drive style. The sockets do not affect each other.

Top module: `gps_port_top`

## Requirements
- R1: After reset every control byte, pointer, main index and held output byte is 0. Each strobe pin is therefore high with its output enable low.
- R2: A write with `addr_i`=0 loads the main index. A read with `addr_i`=0 returns it.
- R3: Main index 2Eh (socket 0) or 6Eh (socket 1) on the data port (`addr_i`=1) reads and writes that socket's pointer register.
- R4: Main index 2Fh (socket 0) or 6Fh (socket 1) opens the socket's data window. With pointer 0Bh the window reaches the socket's control byte, and all eight bits are read/write. The control byte fields are:
  - bit 5: active-high strobe
  - bit 4: fire on write
  - bit 3: fire on read
  - bit 2: push-pull drive
  - bits 7:6 and 1:0: spare storage
- R5: With pointer 0Ah the window is the external data port. While bit 4 is set, a write asserts the strobe for exactly the cycles the write command is high. During those cycles `ext_out_o` carries `wdata_i`, and afterwards it holds the last byte written.
- R6: While bit 3 is set, a read of the external data port asserts the strobe during the read cycles. A read of that port returns the socket's `ext_in_i`.
- R7: With bit 5 clear the strobe is active-low. With bit 5 set it is active-high.
- R8: With bit 2 set the output enable is always high. With bit 2 clear the output enable is high only while the strobe is active.
- R9: No strobe fires when any of the following holds:
  - the matching enable bit is clear;
  - no command is active;
  - the main index selects another socket.
- R10: A window access with a pointer other than 0Ah or 0Bh, or at an unmapped main index, reads 0 and its write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Block select |
| addr_i | input | 1 | 0 = index port, 1 = data port |
| rd_i | input | 1 | Host read command |
| wr_i | input | 1 | Host write command |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, 0 when nothing is read |
| ext_in_i | input | 2x8 | External status byte per socket |
| ext_out_o | output | 2x8 | External output byte per socket |
| stb_o | output | 2 | Strobe pin level per socket |
| stb_oe_o | output | 2 | Strobe pin output enable per socket |

## Verification
On every cycle, the assertions check three things:
- the main index, the pointers, the control bytes and the held output bytes change only under a write that decodes to them;
- an open-drain strobe is never enabled while the bus is idle;
- the output byte stays stable while it drives a write strobe.

Only the bench's scenarios can show the mapping to specific values: polarity and drive mode as they appear on the pins, the read data returned from each window, the independence of the two sockets, and the return to the reset state.

// File: rtl/gps_pkg.sv
package gps_pkg;
  localparam int unsigned DW = 8;

  typedef struct packed {
    logic [1:0] spare_hi;
    logic       act_high;
    logic       on_wr;
    logic       on_rd;
    logic       push_pull;
    logic [1:0] spare_lo;
  } gps_ctrl_t;
endpackage

// File: rtl/gps_index_dec.sv
module gps_index_dec #(
  parameter int unsigned SOCK_N      = 2,
  parameter int unsigned IDX_W       = 8,
  parameter int unsigned PTR_BASE    = 'h2E,
  parameter int unsigned SOCK_STRIDE = 'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wdata_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [SOCK_N-1:0] ptr_sel_o,
  output logic [SOCK_N-1:0] win_sel_o
);
  logic [IDX_W-1:0] idx_q;
  logic             idx_wr;
  logic             data_acc;

  assign idx_wr   = cs_i && !addr_i && wr_i;
  assign data_acc = cs_i && addr_i;
  assign idx_o    = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (idx_wr) idx_q <= wdata_i;
  end

  for (genvar s = 0; s < SOCK_N; s++) begin : g_sock
    localparam logic [IDX_W-1:0] PtrIdx = IDX_W'(PTR_BASE + s * SOCK_STRIDE);
    localparam logic [IDX_W-1:0] WinIdx = IDX_W'(PTR_BASE + s * SOCK_STRIDE + 1);
    assign ptr_sel_o[s] = data_acc && (idx_q == PtrIdx);
    assign win_sel_o[s] = data_acc && (idx_q == WinIdx);
  end

  a_r2_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_wr |=> $stable(idx_q));
  a_r2_idx_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr |=> idx_q == $past(wdata_i));
endmodule

// File: rtl/gps_socket.sv
module gps_socket
  import gps_pkg::*;
#(
  parameter logic [DW-1:0] CTRL_SEL = 8'h0B,
  parameter logic [DW-1:0] DATA_SEL = 8'h0A
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ptr_sel_i,
  input  logic          win_sel_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] ext_in_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] ext_out_o,
  output logic          stb_o,
  output logic          stb_oe_o
);
  logic [DW-1:0] xidx_q;
  logic [DW-1:0] xout_q;
  gps_ctrl_t     ctrl_q;
  logic          ctrl_hit, data_hit, fire;

  assign ctrl_hit = win_sel_i && (xidx_q == CTRL_SEL);
  assign data_hit = win_sel_i && (xidx_q == DATA_SEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xidx_q <= '0;
      ctrl_q <= '0;
      xout_q <= '0;
    end else begin
      if (ptr_sel_i && wr_i) xidx_q <= wdata_i;
      if (ctrl_hit && wr_i)  ctrl_q <= gps_ctrl_t'(wdata_i);
      if (data_hit && wr_i)  xout_q <= wdata_i;
    end
  end

  // strobe is combinational so it spans exactly the command cycles
  assign fire      = data_hit && ((rd_i && ctrl_q.on_rd) || (wr_i && ctrl_q.on_wr));
  assign stb_o     = ctrl_q.act_high ? fire : !fire;
  assign stb_oe_o  = ctrl_q.push_pull || fire;
  assign ext_out_o = (data_hit && wr_i) ? wdata_i : xout_q;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (ptr_sel_i)     rdata_o = xidx_q;
      else if (ctrl_hit) rdata_o = ctrl_q;
      else if (data_hit) rdata_o = ext_in_i;
    end
  end

  a_r3_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ptr_sel_i && wr_i) |=> $stable(xidx_q));
  a_r4_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_hit && wr_i) |=> $stable(ctrl_q));
  a_r5_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_hit && wr_i) |=> $stable(xout_q));
  a_r5_out_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_hit && wr_i && $stable(wdata_i) && $past(data_hit && wr_i)) |-> $stable(ext_out_o));
  a_r8_od_idle_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.push_pull && !rd_i && !wr_i) |-> !stb_oe_o);
endmodule

// File: rtl/gps_port_top.sv
module gps_port_top
  import gps_pkg::*;
#(
  parameter int unsigned SOCK_N      = 2,
  parameter int unsigned PTR_BASE    = 'h2E,
  parameter int unsigned SOCK_STRIDE = 'h40
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cs_i,
  input  logic                      addr_i,
  input  logic                      rd_i,
  input  logic                      wr_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [DW-1:0]             rdata_o,
  input  logic [SOCK_N-1:0][DW-1:0] ext_in_i,
  output logic [SOCK_N-1:0][DW-1:0] ext_out_o,
  output logic [SOCK_N-1:0]         stb_o,
  output logic [SOCK_N-1:0]         stb_oe_o
);
  logic [DW-1:0]             idx;
  logic [SOCK_N-1:0]         ptr_sel, win_sel;
  logic [SOCK_N-1:0][DW-1:0] sock_rdata;

  gps_index_dec #(
    .SOCK_N(SOCK_N), .IDX_W(DW), .PTR_BASE(PTR_BASE), .SOCK_STRIDE(SOCK_STRIDE)
  ) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .addr_i(addr_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .idx_o(idx), .ptr_sel_o(ptr_sel), .win_sel_o(win_sel)
  );

  for (genvar s = 0; s < SOCK_N; s++) begin : g_sock
    gps_socket u_sock (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .ptr_sel_i(ptr_sel[s]), .win_sel_i(win_sel[s]),
      .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i),
      .ext_in_i(ext_in_i[s]), .rdata_o(sock_rdata[s]),
      .ext_out_o(ext_out_o[s]), .stb_o(stb_o[s]), .stb_oe_o(stb_oe_o[s])
    );
  end

  always_comb begin
    rdata_o = (cs_i && !addr_i && rd_i) ? idx : '0;
    for (int s = 0; s < SOCK_N; s++) rdata_o |= sock_rdata[s];
  end
endmodule

// File: tb/gps_port_top_tb_top.sv
`timescale 1ns/1ps
module gps_port_top_tb_top;
  logic clk = 0, rst_n = 0;
  logic cs = 0, addr = 0, rd = 0, wr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [1:0][7:0] ext_in, ext_out;
  logic [1:0] stb, oe;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign ext_in[0] = 8'hA5;
  assign ext_in[1] = 8'h3C;

  gps_port_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .ext_in_i(ext_in), .ext_out_o(ext_out),
    .stb_o(stb), .stb_oe_o(oe)
  );

  // {addr, wr, wdata, expected read}
  localparam int NV = 22;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0,1'b1,8'h2E,8'h00}, {1'b0,1'b0,8'h00,8'h2E}, {1'b1,1'b1,8'h0B,8'h00},
    {1'b1,1'b0,8'h00,8'h0B}, {1'b0,1'b1,8'h2F,8'h00}, {1'b1,1'b0,8'h00,8'h00},
    {1'b1,1'b1,8'hC3,8'h00}, {1'b1,1'b0,8'h00,8'hC3}, {1'b0,1'b1,8'h6E,8'h00},
    {1'b1,1'b0,8'h00,8'h00}, {1'b0,1'b1,8'h6F,8'h00}, {1'b1,1'b0,8'h00,8'h00},
    {1'b1,1'b1,8'hFF,8'h00}, {1'b0,1'b1,8'h6E,8'h00}, {1'b1,1'b1,8'h0B,8'h00},
    {1'b0,1'b1,8'h6F,8'h00}, {1'b1,1'b0,8'h00,8'h00}, {1'b0,1'b1,8'h13,8'h00},
    {1'b1,1'b0,8'h00,8'h00}, {1'b1,1'b1,8'h77,8'h00}, {1'b0,1'b1,8'h2F,8'h00},
    {1'b1,1'b0,8'h00,8'hC3}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic a, input logic [7:0] d);
    @(negedge clk); cs = 1; addr = a; wr = 1; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic brd(input logic a, output logic [7:0] d);
    @(negedge clk); cs = 1; addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic hold_wr(input logic [7:0] d);
    @(negedge clk); cs = 1; addr = 1; wr = 1; wdata = d; #1;
  endtask

  task automatic hold_rd();
    @(negedge clk); cs = 1; addr = 1; rd = 1; #1;
  endtask

  task automatic bend();
    @(negedge clk); cs = 0; rd = 0; wr = 0; #1;
  endtask

  task automatic set_reg(input logic [7:0] ptr_idx, input logic [7:0] sel, input logic [7:0] val);
    bwr(0, ptr_idx); bwr(1, 8'h0B); bwr(0, ptr_idx + 8'h01); bwr(1, val);
    bwr(0, ptr_idx); bwr(1, sel);   bwr(0, ptr_idx + 8'h01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    chk("R1 stb idle", stb, 2'b11);
    chk("R1 oe idle", oe, 2'b00);
    chk("R1 ext_out", ext_out, 16'h0000);
    rst_n = 1;
    brd(0, r); chk("R1 index reset", r, 8'h00);

    foreach (VEC[i]) begin
      if (VEC[i][16]) bwr(VEC[i][17], VEC[i][15:8]);
      else begin
        brd(VEC[i][17], r);
        chk($sformatf("R2,R3,R4,R10 vec%0d", i), r, VEC[i][7:0]);
      end
    end

    // socket 0: write port, active-low, open drain
    set_reg(8'h2E, 8'h0A, 8'h10);
    chk("R7 low idle level", stb[0], 1'b1);
    chk("R8 od idle oe", oe[0], 1'b0);
    hold_wr(8'h5A);
    chk("R5 R7 wr strobe low", stb[0], 1'b0);
    chk("R8 od active oe", oe[0], 1'b1);
    chk("R5 out during strobe", ext_out[0], 8'h5A);
    chk("R9 other socket quiet", {stb[1], oe[1]}, 2'b10);
    @(posedge clk); #1;
    chk("R5 strobe spans second cycle", stb[0], 1'b0);
    bend();
    chk("R5 strobe ends", {stb[0], oe[0]}, 2'b10);
    chk("R5 out held", ext_out[0], 8'h5A);
    hold_rd();
    chk("R9 no read strobe", stb[0], 1'b1);
    chk("R6 read ext_in", rdata, 8'hA5);
    bend();

    // socket 0: read port, active-high, push-pull
    set_reg(8'h2E, 8'h0A, 8'h2C);
    chk("R7 R8 high pp idle", {stb[0], oe[0]}, 2'b01);
    hold_rd();
    chk("R6 rd strobe", {stb[0], oe[0]}, 2'b11);
    chk("R6 rd data", rdata, 8'hA5);
    bend();
    chk("R6 rd strobe ends", stb[0], 1'b0);
    hold_wr(8'h66);
    chk("R9 no wr strobe", stb[0], 1'b0);
    bend();
    chk("R5 out updated", ext_out[0], 8'h66);

    // socket 1: write port, active-high, open drain
    set_reg(8'h6E, 8'h0A, 8'h30);
    hold_wr(8'h81);
    chk("R7 R8 sock1 strobe", {stb[1], oe[1]}, 2'b11);
    chk("R9 sock0 untouched", {stb[0], oe[0], ext_out[0]}, {2'b01, 8'h66});
    chk("R5 sock1 out", ext_out[1], 8'h81);
    bend();
    chk("R8 sock1 float", oe[1], 1'b0);
    bwr(0, 8'h2F);
    hold_wr(8'h11);
    chk("R9 other index quiet", {stb[1], oe[1]}, 2'b00);
    bend();

    // socket 1: unmapped pointer
    bwr(0, 8'h6E); bwr(1, 8'h05); bwr(0, 8'h6F);
    hold_wr(8'h99);
    chk("R9 R10 bad ptr quiet", {stb[1], oe[1]}, 2'b00);
    bend();
    chk("R10 bad ptr write ignored", ext_out[1], 8'h81);
    brd(1, r); chk("R10 bad ptr reads 0", r, 8'h00);
    bwr(0, 8'h6E); bwr(1, 8'h0B); bwr(0, 8'h6F);
    brd(1, r); chk("R10 ctrl kept", r, 8'h30);

    // reset again
    @(negedge clk); rst_n = 0; #1;
    chk("R1 reset stb", {stb, oe}, 4'b1100);
    chk("R1 reset out", ext_out, 16'h0000);
    @(negedge clk); rst_n = 1;
    brd(0, r); chk("R1 reset index", r, 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule